// File: doc/BRIEF.md
# Serial RAM Bootloader

This block fetches a program over a UART receive line, stores it in on-chip RAM and then asks the processor to start running it. After reset is released it watches a security option bit and a set of mode-select strap inputs. If the security bit reads 1 and the straps keep their required pattern for a fixed number of clock cycles, the block latches loader mode. Any other outcome latches normal mode, and the block stays idle until the next reset.

In loader mode every correctly framed byte is written to RAM through a single write port. The first byte goes to the load base (0x0050), and each later byte goes to the next address up. The first byte is a length that counts itself. Once that many bytes have been stored, the block pulses a jump request, and a 16-bit output holds the entry address, which is one above the load base. The host can hold off execution on purpose by sending fewer bytes than the count. The block then waits for more bytes indefinitely, and a later reset leaves the RAM as it is.

The receiver runs at 16x oversampling. Its tick divider is derived from the reference-clock-to-baud ratio, so the default of 4 MHz and 9600 baud gives a divide-by-26 tick.

Top module: `serial_ram_loader`

## Requirements
- R1: Loader mode is never entered while `sec_opt_i` reads 0 during the detection window. `loader_active_o` stays 0 and no RAM write occurs.
- R2: With `sec_opt_i`=1 and `mode_strap_i`==STRAP_REQ (default 4'b1101) on every clock, `loader_active_o` rises exactly HOLD_CYC rising edges after reset release. A mismatch before that latches normal mode until the next reset, even if the straps later match.
- R3: The receive line idles high and each frame is 8N1: one low start bit, eight data bits LSB first, one high stop bit. A bit lasts 16 ticks, and a tick comes every round(CLK_HZ/(16*BAUD)) clocks. Each bit is sampled at mid-bit.
- R4: The n-th accepted byte (n from 0) is written to address LOAD_BASE+n (default 0x0050+n) with `ram_we_o` high for exactly one clock.
- R5: The first byte is a self-inclusive count C. When C bytes have been written (C ≥ 2), `jump_o` pulses for one clock, in the same cycle as the final write. It pulses once per reset.
- R6: `jump_addr_o` holds LOAD_BASE+1 (default 0x0051) whenever `jump_o` is high and from reset onward.
- R7: A count of 0 or 1 raises `jump_o` with the write of the count byte. Bytes that arrive after the jump are not written.
- R8: If fewer than C bytes arrive, `jump_o` never pulses. A reset into normal mode produces no RAM write, so the stored contents are untouched.
- R9: A start bit that is high again at its mid-point is discarded. No byte is produced, and the next valid frame is received normally.
- R10: A frame whose stop bit samples low pulses `frame_err_o` for one clock. It writes nothing and does not advance the load address. The receiver waits for the line to return high before it looks for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sec_opt_i | input | 1 | Security option bit, 1 = inactive (loader allowed) |
| mode_strap_i | input | STRAP_W | Mode-select straps compared against STRAP_REQ |
| rxd_i | input | 1 | UART receive line, idle high |
| ram_we_o | output | 1 | RAM write enable, one clock per stored byte |
| ram_addr_o | output | ADDR_W | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |
| jump_o | output | 1 | One-clock request to start the loaded program |
| jump_addr_o | output | ADDR_W | Entry address of the loaded program |
| loader_active_o | output | 1 | Loader mode latched |
| frame_err_o | output | 1 | One-clock pulse on a missing stop bit |

## Verification
The final RAM write and the jump request are meant to fall in the same clock cycle. The bench provokes this across a sweep of counts from 0 to 9 plus 17 and 40, each with computed payload bytes. It judges the result by sampling `ram_we_o` whenever `jump_o` is high and counting jump pulses against the writes stored in its RAM model. For counts of 0 and 1 the coincidence lands on the count byte itself. A further byte is then sent to show that nothing is written after the jump.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

  typedef enum logic [1:0] {
    MD_CHECK,
    MD_LOADER,
    MD_NORMAL
  } mode_e;

  typedef enum logic {
    WS_LOAD,
    WS_DONE
  } wseq_e;

  function automatic int unsigned tick_div(int unsigned clk_hz, int unsigned baud,
                                           int unsigned ovs);
    int unsigned d;
    d = (clk_hz + (baud * ovs) / 2) / (baud * ovs);
    return (d == 0) ? 1 : d;
  endfunction
endpackage

// File: rtl/ldr_mode_detect.sv
module ldr_mode_detect
  import ldr_pkg::*;
#(
  parameter int unsigned       STRAP_W   = 4,
  parameter logic [STRAP_W-1:0] STRAP_REQ = 4'b1101,
  parameter int unsigned       HOLD_CYC  = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sec_opt_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               loader_o
);
  localparam int unsigned CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);

  mode_e            mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             match;

  assign match = sec_opt_i && (strap_i == STRAP_REQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_CHECK;
      cnt_q  <= '0;
    end else if (mode_q == MD_CHECK) begin
      if (!match) begin
        mode_q <= MD_NORMAL;
      end else if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
        mode_q <= MD_LOADER;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign loader_o = (mode_q == MD_LOADER);
endmodule

// File: rtl/ldr_uart_rx.sv
module ldr_uart_rx
  import ldr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 4_000_000,
  parameter int unsigned BAUD   = 9600,
  parameter int unsigned OVS    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       frame_err_o
);
  localparam int unsigned DIV   = tick_div(CLK_HZ, BAUD, OVS);
  localparam int unsigned DIV_W = (DIV < 2) ? 1 : $clog2(DIV);
  localparam int unsigned OVS_W = $clog2(OVS);
  localparam logic [OVS_W-1:0] MID  = OVS_W'(OVS / 2 - 1);
  localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);

  logic [1:0]       sync_q;
  logic             rx;
  logic [DIV_W-1:0] div_q;
  logic             tick;
  rx_state_e        st_q;
  logic [OVS_W-1:0] ovs_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end
  assign rx = sync_q[1];

  generate
    if (DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= '0;
      end
    end else begin : g_div
      assign tick = (div_q == DIV_W'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= RX_IDLE;
      ovs_q       <= '0;
      bit_q       <= '0;
      sh_q        <= '0;
      byte_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      byte_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (tick && !rx) begin
          st_q  <= RX_START;
          ovs_q <= '0;
        end
        RX_START: if (tick) begin
          if (ovs_q == MID) begin
            ovs_q <= '0;
            bit_q <= '0;
            st_q  <= rx ? RX_IDLE : RX_DATA;  // false start when high
          end else begin
            ovs_q <= ovs_q + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (ovs_q == LAST) begin
            ovs_q <= '0;
            sh_q  <= {rx, sh_q[7:1]};
            if (bit_q == 3'd7) st_q <= RX_STOP;
            else               bit_q <= bit_q + 1'b1;
          end else begin
            ovs_q <= ovs_q + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (ovs_q == LAST) begin
            ovs_q <= '0;
            if (rx) begin
              byte_vld_o <= 1'b1;
              st_q       <= RX_IDLE;
            end else begin
              frame_err_o <= 1'b1;
              st_q        <= RX_BREAK;
            end
          end else begin
            ovs_q <= ovs_q + 1'b1;
          end
        end
        RX_BREAK: if (rx) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign byte_o = sh_q;
endmodule

// File: rtl/ldr_write_seq.sv
module ldr_write_seq
  import ldr_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]    LOAD_BASE = 16'h0050
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              jump_o
);
  wseq_e      st_q;
  logic [7:0] idx_q;
  logic [7:0] cnt_q;
  logic [7:0] eff_cnt;
  logic [8:0] idx_nxt;

  // the count byte governs its own write
  assign eff_cnt = (idx_q == 8'd0) ? byte_i : cnt_q;
  assign idx_nxt = {1'b0, idx_q} + 9'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= WS_LOAD;
      idx_q   <= '0;
      cnt_q   <= '0;
      we_o    <= 1'b0;
      addr_o  <= LOAD_BASE;
      wdata_o <= '0;
      jump_o  <= 1'b0;
    end else begin
      we_o   <= 1'b0;
      jump_o <= 1'b0;
      if (enable_i && byte_vld_i && st_q == WS_LOAD) begin
        we_o    <= 1'b1;
        addr_o  <= LOAD_BASE + ADDR_W'(idx_q);
        wdata_o <= byte_i;
        idx_q   <= idx_nxt[7:0];
        if (idx_q == 8'd0) cnt_q <= byte_i;
        if (idx_nxt >= {1'b0, eff_cnt}) begin
          jump_o <= 1'b1;
          st_q   <= WS_DONE;
        end
      end
    end
  end
endmodule

// File: rtl/serial_ram_loader.sv
module serial_ram_loader
  import ldr_pkg::*;
#(
  parameter int unsigned          CLK_HZ    = 4_000_000,
  parameter int unsigned          BAUD      = 9600,
  parameter int unsigned          OVS       = 16,
  parameter int unsigned          ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]    LOAD_BASE = 16'h0050,
  parameter int unsigned          STRAP_W   = 4,
  parameter logic [STRAP_W-1:0]   STRAP_REQ = 4'b1101,
  parameter int unsigned          HOLD_CYC  = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sec_opt_i,
  input  logic [STRAP_W-1:0] mode_strap_i,
  input  logic               rxd_i,
  output logic               ram_we_o,
  output logic [ADDR_W-1:0]  ram_addr_o,
  output logic [7:0]         ram_wdata_o,
  output logic               jump_o,
  output logic [ADDR_W-1:0]  jump_addr_o,
  output logic               loader_active_o,
  output logic               frame_err_o
);
  localparam logic [ADDR_W-1:0] ENTRY = LOAD_BASE + ADDR_W'(1);

  logic       loader;
  logic       rx_vld;
  logic [7:0] rx_byte;
  logic       rx_ferr;

  ldr_mode_detect #(
    .STRAP_W  (STRAP_W),
    .STRAP_REQ(STRAP_REQ),
    .HOLD_CYC (HOLD_CYC)
  ) i_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sec_opt_i(sec_opt_i),
    .strap_i  (mode_strap_i),
    .loader_o (loader)
  );

  ldr_uart_rx #(
    .CLK_HZ(CLK_HZ),
    .BAUD  (BAUD),
    .OVS   (OVS)
  ) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rxd_i      (rxd_i),
    .byte_vld_o (rx_vld),
    .byte_o     (rx_byte),
    .frame_err_o(rx_ferr)
  );

  ldr_write_seq #(
    .ADDR_W   (ADDR_W),
    .LOAD_BASE(LOAD_BASE)
  ) i_wseq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (loader),
    .byte_vld_i(rx_vld),
    .byte_i    (rx_byte),
    .we_o      (ram_we_o),
    .addr_o    (ram_addr_o),
    .wdata_o   (ram_wdata_o),
    .jump_o    (jump_o)
  );

  assign jump_addr_o     = ENTRY;
  assign loader_active_o = loader;
  assign frame_err_o     = rx_ferr && loader;
endmodule

// File: rtl/ldr_checker.sv
module ldr_checker #(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] LOAD_BASE = 16'h0050
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sec_opt_i,
  input logic              ram_we_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              jump_o,
  input logic [ADDR_W-1:0] jump_addr_o,
  input logic              loader_active_o,
  input logic              frame_err_o
);
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (ram_we_o) begin
      seen_q <= 1'b1;
      last_q <= ram_addr_o;
    end
  end

  assert_sec_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loader_active_o) |-> $past(sec_opt_i));
  assert_first_base_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && !seen_q) |-> ram_addr_o == LOAD_BASE);
  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && seen_q) |-> ram_addr_o == last_q + ADDR_W'(1));
  assert_we_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !ram_we_o);
  assert_jump_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |=> !jump_o);
  assert_jump_with_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> ram_we_o);
  assert_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> jump_addr_o == LOAD_BASE + ADDR_W'(1));
  assert_no_write_normal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loader_active_o |-> !ram_we_o);
  assert_ferr_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !ram_we_o);
endmodule

bind serial_ram_loader ldr_checker #(
  .ADDR_W   (ADDR_W),
  .LOAD_BASE(LOAD_BASE)
) i_ldr_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sec_opt_i      (sec_opt_i),
  .ram_we_o       (ram_we_o),
  .ram_addr_o     (ram_addr_o),
  .jump_o         (jump_o),
  .jump_addr_o    (jump_addr_o),
  .loader_active_o(loader_active_o),
  .frame_err_o    (frame_err_o)
);

// File: tb/test_serial_ram_loader.sv
`timescale 1ns/1ps
module test_serial_ram_loader;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ     = 32000;
  localparam int unsigned BAUD       = 1000;
  localparam int unsigned HOLD       = 30;
  localparam logic [3:0]  REQ        = 4'b1101;
  localparam int unsigned DIV_TB     = (CLK_HZ + BAUD * 8) / (BAUD * 16);
  localparam int unsigned BIT        = 16 * DIV_TB;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sec_opt_i = 1'b1;
  logic [3:0]  mode_strap_i = REQ;
  logic        rxd_i = 1'b1;
  logic        ram_we_o;
  logic [15:0] ram_addr_o;
  logic [7:0]  ram_wdata_o;
  logic        jump_o;
  logic [15:0] jump_addr_o;
  logic        loader_active_o;
  logic        frame_err_o;

  int vectors = 0;
  int errors  = 0;
  int wr_cnt, jmp_cnt, jmp_alone, ferr_cnt;
  logic [15:0] last_addr;
  logic [7:0]  mem [0:511];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  serial_ram_loader #(
    .CLK_HZ   (CLK_HZ),
    .BAUD     (BAUD),
    .HOLD_CYC (HOLD),
    .STRAP_REQ(REQ)
  ) i_serial_ram_loader (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sec_opt_i      (sec_opt_i),
    .mode_strap_i   (mode_strap_i),
    .rxd_i          (rxd_i),
    .ram_we_o       (ram_we_o),
    .ram_addr_o     (ram_addr_o),
    .ram_wdata_o    (ram_wdata_o),
    .jump_o         (jump_o),
    .jump_addr_o    (jump_addr_o),
    .loader_active_o(loader_active_o),
    .frame_err_o    (frame_err_o)
  );

  always @(negedge clk_i) begin
    if (ram_we_o) begin
      mem[ram_addr_o[8:0]] = ram_wdata_o;
      wr_cnt    = wr_cnt + 1;
      last_addr = ram_addr_o;
    end
    if (jump_o) begin
      jmp_cnt = jmp_cnt + 1;
      if (!ram_we_o) jmp_alone = jmp_alone + 1;
    end
    if (frame_err_o) ferr_cnt = ferr_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    wr_cnt = 0; jmp_cnt = 0; jmp_alone = 0; ferr_cnt = 0; last_addr = '0;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  // reset pulse, release on a falling edge
  task automatic do_reset(input logic sec, input logic [3:0] st, input bit clear);
    @(negedge clk_i);
    rst_ni = 1'b0; rxd_i = 1'b1; sec_opt_i = sec; mode_strap_i = st;
    if (clear) clr_mon();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stop);
    @(negedge clk_i);
    rxd_i = 1'b0;
    repeat (BIT) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      rxd_i = b[i];
      repeat (BIT) @(negedge clk_i);
    end
    rxd_i = stop;
    repeat (BIT) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (BIT / 2) @(negedge clk_i);
  endtask

  function automatic logic [7:0] pay(input int n, input int k);
    return 8'((n * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic load_run(input int n);
    int exp_w;
    exp_w = (n < 1) ? 1 : n;
    do_reset(1'b1, REQ, 1'b1);
    repeat (HOLD + 2) @(negedge clk_i);
    send_byte(8'(n), 1'b1);
    for (int k = 1; k < n; k++) send_byte(pay(n, k), 1'b1);
    if (n < 2) send_byte(8'h5A, 1'b1);  // after jump: must be dropped (R7)
    repeat (BIT) @(negedge clk_i);
    chk($sformatf("R5 writes n=%0d", n), wr_cnt, exp_w);
    chk($sformatf("R5 jump count n=%0d", n), jmp_cnt, 1);
    chk($sformatf("R5 jump with final write n=%0d", n), jmp_alone, 0);
    chk($sformatf("R4 count byte at base n=%0d", n), mem[9'h050], 8'(n));
    chk($sformatf("R4 last addr n=%0d", n), last_addr, 16'h0050 + 16'(exp_w - 1));
    chk($sformatf("R6 entry n=%0d", n), jump_addr_o, 16'h0051);
    if (n < 2) chk($sformatf("R7 no write after jump n=%0d", n), mem[9'h051], 8'h00);
    for (int k = 1; k < n; k++)
      chk($sformatf("R3 data n=%0d k=%0d", n, k), mem[9'h050 + 9'(k)], pay(n, k));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    vectors++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    clr_mon();
    // reset state
    repeat (2) @(negedge clk_i);
    chk("R4 reset we", ram_we_o, 0);
    chk("R5 reset jump", jump_o, 0);
    chk("R2 reset active", loader_active_o, 0);
    chk("R10 reset ferr", frame_err_o, 0);
    chk("R6 reset entry", jump_addr_o, 16'h0051);

    // R2: exact detection delay
    do_reset(1'b1, REQ, 1'b1);
    repeat (HOLD - 1) @(posedge clk_i);
    @(negedge clk_i);
    chk("R2 active one edge early", loader_active_o, 0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R2 active at hold", loader_active_o, 1);

    // R2: strap broken early latches normal mode
    do_reset(1'b1, REQ, 1'b1);
    repeat (10) @(negedge clk_i);
    mode_strap_i = 4'b0101;
    repeat (4) @(negedge clk_i);
    mode_strap_i = REQ;
    repeat (HOLD + 10) @(negedge clk_i);
    chk("R2 early break stays normal", loader_active_o, 0);
    send_byte(8'h02, 1'b1);
    chk("R2 no write in normal", wr_cnt, 0);

    // R1: security bit active
    do_reset(1'b0, REQ, 1'b1);
    repeat (HOLD + 10) @(negedge clk_i);
    chk("R1 secured stays normal", loader_active_o, 0);
    send_byte(8'h01, 1'b1);
    chk("R1 no write when secured", wr_cnt, 0);

    // R3..R7: count sweep
    for (int n = 0; n < 10; n++) load_run(n);
    load_run(17);
    load_run(40);

    // R8: hold-off then reset into normal mode
    do_reset(1'b1, REQ, 1'b1);
    repeat (HOLD + 2) @(negedge clk_i);
    send_byte(8'd6, 1'b1);
    for (int k = 1; k < 4; k++) send_byte(pay(6, k), 1'b1);
    repeat (20 * BIT) @(negedge clk_i);
    chk("R8 no jump on short load", jmp_cnt, 0);
    chk("R8 partial writes", wr_cnt, 4);
    wr_cnt = 0;
    do_reset(1'b1, 4'b0000, 1'b0);
    repeat (HOLD + 10) @(negedge clk_i);
    send_byte(8'hEE, 1'b1);
    chk("R8 no write after reset", wr_cnt, 0);
    chk("R8 ram kept", mem[9'h053], pay(6, 3));

    // R9: false start
    do_reset(1'b1, REQ, 1'b1);
    repeat (HOLD + 2) @(negedge clk_i);
    rxd_i = 1'b0;
    repeat (BIT / 4) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (2 * BIT) @(negedge clk_i);
    chk("R9 glitch gives no byte", wr_cnt, 0);
    send_byte(8'd2, 1'b1);
    send_byte(8'hA5, 1'b1);
    chk("R9 next frame count", mem[9'h050], 8'd2);
    chk("R9 next frame data", mem[9'h051], 8'hA5);
    chk("R9 no frame error", ferr_cnt, 0);

    // R10: missing stop bit
    do_reset(1'b1, REQ, 1'b1);
    repeat (HOLD + 2) @(negedge clk_i);
    send_byte(8'd3, 1'b1);
    send_byte(8'h3C, 1'b0);
    chk("R10 frame error pulse", ferr_cnt, 1);
    chk("R10 bad byte not written", wr_cnt, 1);
    send_byte(8'h77, 1'b1);
    send_byte(8'h88, 1'b1);
    chk("R10 address not advanced", mem[9'h051], 8'h77);
    chk("R10 following byte", mem[9'h052], 8'h88);
    chk("R10 jump after recovery", jmp_cnt, 1);

    summary();
    $finish;
  end
endmodule